// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block turns interrupt events raised by on-chip sources into fixed 16-byte vectors and stores them in a circular buffer held in system memory. Each accepted event is laid out as four 32-bit words and written through a simple one-word-per-cycle memory write port. A byte-addressed write pointer tracks the next free slot. A sticky overflow flag records that the ring filled up before software drained it. As an option, the write pointer can be mirrored to a writeback word in memory after each vector.

Software configures the ring through a small register file. It sets the enables, the ring size as log2 of the length in 32-bit words, the 256-byte-aligned base address and the writeback address. Software also owns the read pointer and can load the write pointer. The interrupt output stays asserted while enabled data is waiting: either the read pointer trails the write pointer or an overflow is pending.

Top module: `ivr_producer`

## Requirements
- R1: After reset, both pointers read 0, the overflow flag is clear, `irq` and `ev_ready` are low, and no memory write occurs.
- R2: An event is accepted (`ev_ready` high) only when the ring-enable bit (control bit 0) and the interrupt-enable bit (control bit 1) are both set. While either bit is clear, events cause no memory write and leave the write pointer unchanged.
- R3: An accepted event produces four consecutive memory writes, one per cycle, at byte addresses B+W, B+W+4, B+W+8 and B+W+12. B is the base register shifted left by 8 into a 40-bit address, and W is the write pointer. Word 0 holds the source ID in [7:0]. Word 1 holds the 28-bit data in [27:0]. Word 2 holds the ring ID in [7:0], the VMID in [15:8] and the PASID in [31:16]. Word 3 is zero.
- R4: After each vector the write pointer becomes (W+16) AND M. M is the ring length in bytes minus one, and the length is 4 << size.
- R5: The size field (control bits [8:4]) gives log2 of the ring length in words. Values below 2 act as 2 (a single vector), and values above PTR_W-2 act as PTR_W-2.
- R6: If (W+16) AND M equals the read pointer when a vector is written, the vector is still written at W. The pointer still advances, and the overflow flag is set. The flag reads back as bit 0 of the write pointer register.
- R7: The overflow flag stays set until a control write has bit 3 set. That bit reads back as 0. If a vector sets the flag in the same cycle as the clear, the flag stays set.
- R8: When writeback is enabled (control bit 2), one further memory write follows each vector. It goes to address {WBHI[7:0], WBLO} and carries the updated write pointer register value, overflow bit included. WBHI keeps only 8 bits.
- R9: `irq` is high exactly when both enables are set and either the read pointer differs from the write pointer or the overflow flag is set.
- R10: The register map is CTRL=0, BASE=1, RPTR=2, WPTR=3, WBLO=4, WBHI=5. Writes to RPTR and WPTR load the value ANDed with M and with 16-byte alignment, so software can zero both pointers to idle the ring.
- R11: While a vector or its writeback is in flight, `ev_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted this cycle when valid |
| ev_src | input | 8 | Event source ID |
| ev_data | input | 28 | Event source data |
| ev_ring | input | 8 | Event ring ID |
| ev_vmid | input | 8 | Event VMID |
| ev_pasid | input | 16 | Event PASID |
| mem_wr_en | output | 1 | Memory word write strobe |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| irq | output | 1 | Unread data pending |

## Verification
The checker assumes that the memory port takes every word the cycle it is presented, since the block has no stall input. It also assumes that software loads the write pointer only when no vector is in flight, so that outside such loads the pointer moves only in 16-byte steps under the current mask. The stimulus keeps to these assumptions. It drives events only through the ready handshake, and it touches WPTR only after the expected writes of the previous vector have drained. It also sets the ring size before it loads either pointer.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int ADDR_W = 40;
    localparam int WORD_W = 32;
    localparam int SIZE_W = 5;
    localparam int VEC_BYTES = 16;

    // register indices
    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_BASE = 3'd1;
    localparam logic [2:0] RA_RPTR = 3'd2;
    localparam logic [2:0] RA_WPTR = 3'd3;
    localparam logic [2:0] RA_WBLO = 3'd4;
    localparam logic [2:0] RA_WBHI = 3'd5;

    // control bit positions
    localparam int CB_RING  = 0;
    localparam int CB_INTR  = 1;
    localparam int CB_WB    = 2;
    localparam int CB_OVCLR = 3;
    localparam int CB_SIZE  = 4;

    typedef struct packed {
        logic [7:0]  src;
        logic [27:0] data;
        logic [7:0]  ring;
        logic [7:0]  vmid;
        logic [15:0] pasid;
    } ivr_event_t;

    typedef struct packed {
        logic              ring_en;
        logic              intr_en;
        logic              wb_en;
        logic [SIZE_W-1:0] size;
    } ivr_ctrl_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_W0,
        SQ_W1,
        SQ_W2,
        SQ_W3,
        SQ_WB
    } seq_state_t;

    // one 32-bit word of a vector
    function automatic logic [WORD_W-1:0] vec_word(ivr_event_t e, logic [1:0] k);
        logic [WORD_W-1:0] w;
        case (k)
            2'd0:    w = {24'd0, e.src};
            2'd1:    w = {4'd0, e.data};
            2'd2:    w = {e.pasid, e.vmid, e.ring};
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    input  logic [PTR_W-1:0]    wptr_view,
    output logic [WORD_W-1:0]   reg_rdata,
    output ivr_ctrl_t           ctrl,
    output logic [WORD_W-1:0]   base,
    output logic [PTR_W-1:0]    rptr,
    output logic [ADDR_W-1:0]   wb_addr,
    output logic [PTR_W-1:0]    mask,
    output logic                ovf_clr,
    output logic                wptr_we,
    output logic [PTR_W-1:0]    wptr_wdata
);

    localparam int MAX_LOG2W = PTR_W - 2;

    logic [WORD_W-1:0] wb_lo;
    logic [7:0]        wb_hi;
    int                size_eff;
    logic [PTR_W-1:0]  load_val;

    // effective ring size in log2 words, clamped
    always_comb begin
        size_eff = int'(ctrl.size);
        if (size_eff < 2)
            size_eff = 2;
        else if (size_eff > MAX_LOG2W)
            size_eff = MAX_LOG2W;
        mask = ~({PTR_W{1'b1}} << (size_eff + 2));
    end

    assign load_val   = reg_wdata[PTR_W-1:0] & mask & ~PTR_W'(VEC_BYTES - 1);
    assign ovf_clr    = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_OVCLR];
    assign wptr_we    = reg_we && (reg_addr == RA_WPTR);
    assign wptr_wdata = load_val;
    assign wb_addr    = {wb_hi, wb_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            base  <= '0;
            rptr  <= '0;
            wb_lo <= '0;
            wb_hi <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CTRL: begin
                    ctrl.ring_en <= reg_wdata[CB_RING];
                    ctrl.intr_en <= reg_wdata[CB_INTR];
                    ctrl.wb_en   <= reg_wdata[CB_WB];
                    ctrl.size    <= reg_wdata[CB_SIZE +: SIZE_W];
                end
                RA_BASE: base  <= reg_wdata;
                RA_RPTR: rptr  <= load_val;
                RA_WBLO: wb_lo <= reg_wdata;
                RA_WBHI: wb_hi <= reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {{(WORD_W-CB_SIZE-SIZE_W){1'b0}}, ctrl.size, 1'b0,
                                  ctrl.wb_en, ctrl.intr_en, ctrl.ring_en};
            RA_BASE: reg_rdata = base;
            RA_RPTR: reg_rdata = WORD_W'(rptr);
            RA_WPTR: reg_rdata = WORD_W'(wptr_view);
            RA_WBLO: reg_rdata = wb_lo;
            RA_WBHI: reg_rdata = {24'd0, wb_hi};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  ivr_ctrl_t           ctrl,
    input  logic [WORD_W-1:0]   base,
    input  logic [PTR_W-1:0]    mask,
    input  logic [PTR_W-1:0]    rptr,
    input  logic [ADDR_W-1:0]   wb_addr,
    input  logic                ovf_clr,
    input  logic                wptr_we,
    input  logic [PTR_W-1:0]    wptr_wdata,
    input  logic                ev_valid,
    input  ivr_event_t          ev_in,
    output logic                ev_ready,
    output logic                mem_wr_en,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [PTR_W-1:0]    wptr,
    output logic                ovf,
    output seq_state_t          state
);

    ivr_event_t       ev_q;
    logic [PTR_W-1:0] next_ptr;
    logic             full;
    logic             active;
    logic [1:0]       word_k;
    logic [ADDR_W-1:0] ring_base;

    assign active    = ctrl.ring_en && ctrl.intr_en;
    assign ev_ready  = (state == SQ_IDLE) && active;
    assign next_ptr  = (wptr + PTR_W'(VEC_BYTES)) & mask;
    assign full      = (next_ptr == rptr);
    assign word_k    = 2'(state - SQ_W0);
    assign ring_base = {base, 8'd0};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            wptr  <= '0;
            ovf   <= 1'b0;
            ev_q  <= '0;
        end else begin
            // software actions first; sequencer updates below take priority
            if (wptr_we)
                wptr <= wptr_wdata;
            if (ovf_clr)
                ovf <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (ev_valid && ev_ready) begin
                        ev_q  <= ev_in;
                        state <= SQ_W0;
                    end
                end
                SQ_W0: state <= SQ_W1;
                SQ_W1: state <= SQ_W2;
                SQ_W2: state <= SQ_W3;
                SQ_W3: begin
                    wptr <= next_ptr;
                    if (full)
                        ovf <= 1'b1;
                    state <= ctrl.wb_en ? SQ_WB : SQ_IDLE;
                end
                SQ_WB:   state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_wr_en = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            SQ_W0, SQ_W1, SQ_W2, SQ_W3: begin
                mem_wr_en = 1'b1;
                mem_addr  = ring_base + ADDR_W'(wptr) + ADDR_W'({word_k, 2'b00});
                mem_wdata = vec_word(ev_q, word_k);
            end
            SQ_WB: begin
                mem_wr_en = 1'b1;
                mem_addr  = wb_addr;
                mem_wdata = WORD_W'({wptr[PTR_W-1:1], ovf});
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ivr_producer.sv
module ivr_producer
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_we,
    input  logic [2:0]   reg_addr,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  reg_rdata,
    input  logic         ev_valid,
    output logic         ev_ready,
    input  logic [7:0]   ev_src,
    input  logic [27:0]  ev_data,
    input  logic [7:0]   ev_ring,
    input  logic [7:0]   ev_vmid,
    input  logic [15:0]  ev_pasid,
    output logic         mem_wr_en,
    output logic [39:0]  mem_addr,
    output logic [31:0]  mem_wdata,
    output logic         irq
);

    ivr_ctrl_t         ring_ctrl;
    logic [WORD_W-1:0] ring_base;
    logic [PTR_W-1:0]  rptr_q;
    logic [PTR_W-1:0]  wptr_q;
    logic              ovf_q;
    logic [ADDR_W-1:0] wb_addr;
    logic [PTR_W-1:0]  ring_mask;
    logic              ovf_clr;
    logic              sw_wptr_we;
    logic [PTR_W-1:0]  sw_wptr_val;
    logic [PTR_W-1:0]  wptr_view;
    seq_state_t        seq_state;
    ivr_event_t        ev_bundle;

    assign ev_bundle = '{src: ev_src, data: ev_data, ring: ev_ring,
                         vmid: ev_vmid, pasid: ev_pasid};
    assign wptr_view = {wptr_q[PTR_W-1:1], ovf_q};

    ivr_regs #(.PTR_W(PTR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .wptr_view  (wptr_view),
        .reg_rdata  (reg_rdata),
        .ctrl       (ring_ctrl),
        .base       (ring_base),
        .rptr       (rptr_q),
        .wb_addr    (wb_addr),
        .mask       (ring_mask),
        .ovf_clr    (ovf_clr),
        .wptr_we    (sw_wptr_we),
        .wptr_wdata (sw_wptr_val)
    );

    ivr_seq #(.PTR_W(PTR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ring_ctrl),
        .base       (ring_base),
        .mask       (ring_mask),
        .rptr       (rptr_q),
        .wb_addr    (wb_addr),
        .ovf_clr    (ovf_clr),
        .wptr_we    (sw_wptr_we),
        .wptr_wdata (sw_wptr_val),
        .ev_valid   (ev_valid),
        .ev_in      (ev_bundle),
        .ev_ready   (ev_ready),
        .mem_wr_en  (mem_wr_en),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .wptr       (wptr_q),
        .ovf        (ovf_q),
        .state      (seq_state)
    );

    assign irq = ring_ctrl.ring_en && ring_ctrl.intr_en &&
                 ((rptr_q != wptr_q) || ovf_q);

endmodule

// File: rtl/ivr_producer_chk.sv
module ivr_producer_chk
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input ivr_ctrl_t         ctrl,
    input logic              ev_ready,
    input logic              mem_wr_en,
    input logic [39:0]       mem_addr,
    input logic              irq,
    input logic [PTR_W-1:0]  wptr,
    input logic [PTR_W-1:0]  mask,
    input logic              ovf,
    input logic              ovf_clr,
    input logic              sw_wptr_we,
    input seq_state_t        st
);

    assert_ready_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.ring_en && ctrl.intr_en) |-> !ev_ready);

    assert_ptr_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        wptr[3:0] == 4'd0);

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        !sw_wptr_we |=> (wptr == $past(wptr)) ||
                        (wptr == (($past(wptr) + PTR_W'(16)) & $past(mask))));

    assert_burst_contig_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && (st inside {SQ_W0, SQ_W1, SQ_W2})) |=>
            (mem_wr_en && (mem_addr == $past(mem_addr) + 40'd4)));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl.ring_en && ctrl.intr_en));

    assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (rst)
        (st != SQ_IDLE) |-> !ev_ready);

endmodule

bind ivr_producer ivr_producer_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ring_ctrl),
    .ev_ready   (ev_ready),
    .mem_wr_en  (mem_wr_en),
    .mem_addr   (mem_addr),
    .irq        (irq),
    .wptr       (wptr_q),
    .mask       (ring_mask),
    .ovf        (ovf_q),
    .ovf_clr    (ovf_clr),
    .sw_wptr_we (sw_wptr_we),
    .st         (seq_state)
);

// File: tb/ivr_producer_tb.sv
module ivr_producer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [7:0]  ev_src = '0;
    logic [27:0] ev_data = '0;
    logic [7:0]  ev_ring = '0;
    logic [7:0]  ev_vmid = '0;
    logic [15:0] ev_pasid = '0;
    logic        mem_wr_en;
    logic [39:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [71:0] expq[$];

    // bench model of the ring state
    logic [17:0] m_wptr = '0;
    logic [17:0] m_rptr = '0;
    logic        m_ovf  = 1'b0;
    logic [17:0] m_mask = '0;
    logic        m_wb   = 1'b0;
    logic [39:0] m_base = '0;
    logic [39:0] m_wba  = '0;

    always #10 clk = ~clk;

    ivr_producer u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
        .ev_ready(ev_ready), .ev_src(ev_src), .ev_data(ev_data),
        .ev_ring(ev_ring), .ev_vmid(ev_vmid), .ev_pasid(ev_pasid),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .irq(irq)
    );

    task automatic check(string req, logic [71:0] act, logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: every memory write must match the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_wr_en) begin
            if (expq.size() == 0)
                check("R2/R3 unexpected write", {mem_addr, mem_wdata}, 72'h0);
            else
                check("R3/R8 memory write", {mem_addr, mem_wdata}, expq.pop_front());
        end
    end

    function automatic logic [17:0] size_mask(int sz);
        int s = sz;
        if (s < 2) s = 2;
        if (s > 16) s = 16;
        return 18'((1 << (s + 2)) - 1);
    endfunction

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_ctrl(logic [31:0] d);
        wr_reg(3'd0, d);
        m_mask = size_mask(int'(d[8:4]));
        m_wb   = d[2];
        if (d[3]) m_ovf = 1'b0;
    endtask

    // driver: push expected writes, then hand the event to the DUT
    task automatic send_ev(logic [7:0] s, logic [27:0] dd, logic [7:0] rg,
                           logic [7:0] vm, logic [15:0] pa);
        logic [17:0] nxt;
        expq.push_back({m_base + 40'(m_wptr),       24'd0, s});
        expq.push_back({m_base + 40'(m_wptr) + 4,   4'd0, dd});
        expq.push_back({m_base + 40'(m_wptr) + 8,   pa, vm, rg});
        expq.push_back({m_base + 40'(m_wptr) + 12,  32'd0});
        nxt = (m_wptr + 18'd16) & m_mask;
        if (nxt == m_rptr) m_ovf = 1'b1;
        m_wptr = nxt;
        if (m_wb) expq.push_back({m_wba, 14'd0, m_wptr[17:1], m_ovf});
        do @(negedge clk); while (!ev_ready);
        ev_src = s; ev_data = dd; ev_ring = rg; ev_vmid = vm; ev_pasid = pa;
        ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ev_ready", 72'(ev_ready), 72'h0);
        check("R1 irq", 72'(irq), 72'h0);
        rd_reg(3'd3, v); check("R1 wptr", 72'(v), 72'h0);
        rd_reg(3'd2, v); check("R1 rptr", 72'(v), 72'h0);

        wr_reg(3'd1, 32'h0001_2345); m_base = 40'h00_0123_4500;
        wr_reg(3'd4, 32'h0000_1000);
        wr_reg(3'd5, 32'h0000_01AB); m_wba = 40'hAB_0000_1000;
        rd_reg(3'd5, v); check("R8 wbhi keeps 8 bits", 72'(v), 72'hAB);

        // R2: ring enabled, interrupts off -> events ignored
        set_ctrl(32'h41);
        @(negedge clk);
        ev_valid = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check("R2 ready low with one enable", 72'(ev_ready), 72'h0);
        end
        ev_valid = 1'b0;
        rd_reg(3'd3, v); check("R2 wptr unchanged", 72'(v), 72'h0);

        // R3/R4/R8/R9: normal vectors with writeback, 4-vector ring
        set_ctrl(32'h47);
        send_ev(8'hA5, 28'hFEDCBA9, 8'h11, 8'h22, 16'h3344);
        rd_reg(3'd3, v); check("R4 wptr after one", 72'(v), 72'h10);
        check("R9 irq pending", 72'(irq), 72'h1);
        send_ev(8'h01, 28'h0000001, 8'h02, 8'h03, 16'h0004);
        send_ev(8'h7F, 28'h8000000, 8'hFF, 8'h80, 16'hFFFF);
        rd_reg(3'd3, v); check("R4 wptr after three", 72'(v), 72'h30);
        // R6 last slot: overflow, pointer wraps onto rptr
        send_ev(8'h44, 28'h1234567, 8'h55, 8'h66, 16'h7788);
        rd_reg(3'd3, v); check("R6 overflow flag in wptr", 72'(v), 72'h1);
        check("R9 irq on overflow with equal ptrs", 72'(irq), 72'h1);
        // R6/R7 newest kept, flag sticky
        send_ev(8'h99, 28'h0ABCDEF, 8'h0A, 8'h0B, 16'h0C0D);
        rd_reg(3'd3, v); check("R7 flag sticky", 72'(v), 72'h11);
        set_ctrl(32'h4F);
        rd_reg(3'd3, v); check("R7 flag cleared", 72'(v), 72'h10);
        rd_reg(3'd0, v); check("R10 ctrl readback clear bit 0", 72'(v), 72'h47);
        wr_reg(3'd2, 32'h10); m_rptr = 18'h10;
        @(negedge clk);
        check("R9 idle when pointers equal", 72'(irq), 72'h0);

        // R8: writeback off -> exactly four writes
        set_ctrl(32'h43);
        send_ev(8'h5A, 28'h0F0F0F0, 8'h01, 8'h01, 16'h0101);
        rd_reg(3'd3, v); check("R4 wptr no writeback", 72'(v), 72'h20);
        check("R8 no extra write", 72'(expq.size()), 72'h0);

        // R5: size 0 acts as one-vector ring
        set_ctrl(32'h03);
        wr_reg(3'd3, 32'h0); m_wptr = '0;
        wr_reg(3'd2, 32'h0); m_rptr = '0;
        send_ev(8'hC3, 28'h0000ABC, 8'h0E, 8'h0F, 16'h1010);
        rd_reg(3'd3, v); check("R5 clamped ring overflows", 72'(v), 72'h1);

        // R10/R2: disable and zero pointers
        set_ctrl(32'h08);
        wr_reg(3'd3, 32'h0); m_wptr = '0;
        wr_reg(3'd2, 32'h0); m_rptr = '0;
        @(negedge clk);
        check("R2 ready low when disabled", 72'(ev_ready), 72'h0);
        check("R9 irq low when disabled", 72'(irq), 72'h0);
        rd_reg(3'd3, v); check("R10 wptr zeroed", 72'(v), 72'h0);
        rd_reg(3'd2, v); check("R10 rptr zeroed", 72'(v), 72'h0);
        check("R3 scoreboard drained", 72'(expq.size()), 72'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule